// File: doc/BRIEF.md
# FPU Source Operand Loader

The loader fetches one floating-point source operand and converts it to a single internal extended form: a sign, a 15-bit exponent biased by 16383, and a 64-bit mantissa whose integer bit is explicit. A caller supplies four things when it pulses `start_i`:

- a 3-bit format code;
- a source class;
- the contents of a data register;
- an already-computed operand address.

A register source completes in one cycle. A memory source is gathered over a big-endian read port and completes once the last beat arrives. Every load ends with a one-cycle `done_o`. With it come either a converted result, an illegal-operand flag, or a memory-abort flag.

Integer formats are converted exactly through a leading-zero count. Single and double reals are rebiased, and their zeros, denormals, infinities and NaNs are all handled. Extended reals are unpacked from their 12-byte memory image. Packed decimal operands are refused. Register-sourced operands wider than 32 bits and address-register sources are refused as well.

Top module: `fp_src_loader`

## Requirements
- R1: Format codes are 0 long, 1 single, 2 extended, 3 packed-static, 4 word, 5 double, 6 byte, 7 packed-dynamic. A memory source (class 2 or 3) of byte, word, long or single is fetched in one beat. That beat has `mem_size_o` of 1, 2, 4 or 4 and its data right-justified in `mem_rdata_i`. Double and extended are fetched as 8 or 12 one-byte beats at ascending addresses from `addr_i`. With no stalls, `done_o` rises beats+1 cycles after the start edge.
- R2: For a data-register source (class 0), only byte, word, long and single are legal; they use bits [7:0], [15:0], [31:0] and [31:0] of `dreg_i`. Any other format raises `illegal_o`. A register load finishes with `done_o` in the first cycle after the start edge.
- R3: An address-register source (class 1) always raises `illegal_o` with `done_o` in the first cycle after the start edge, and issues no memory request.
- R4: Packed formats 3 and 7 from memory raise `illegal_o` one cycle after start and issue no memory request.
- R5: Byte and word operands are sign-extended to 32 bits. Every integer converts exactly: a magnitude with its most significant one at bit p gives exponent 16383+p and a mantissa with that one at bit 63. Integer zero gives sign 0, exponent 0 and mantissa 0.
- R6: A normal single or double (exponent field e, bias 127 or 1023) gives exponent e-bias+16383. Its mantissa is bit 63 set, followed by the fraction left-justified; the sign is copied.
- R7: A zero keeps its sign, with exponent 0 and mantissa 0. An all-ones exponent field gives exponent 0x7FFF, mantissa bit 63 clear and the fraction left-justified from bit 62. A denormal is normalised so that its value is exact.
- R8: An extended operand takes its sign and exponent from bytes 0–1 and its mantissa from bytes 4–11. Bytes 2–3 have no effect on the result.
- R9: An abort on any beat ends the load with `done_o` and `abort_o`, zero result fields and no further requests.
- R10: `done_o` is a single-cycle pulse. When `done_o` is low, or when an error flag is set, all result fields are zero. A `start_i` that arrives while a load is in progress is ignored.
- R11: While `mem_ack_i` and `mem_abort_i` are both low, `mem_req_o` stays high with a stable address and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load (sampled when idle) |
| fmt_i | input | 3 | Source format code |
| src_i | input | 2 | Source class: 0 data reg, 1 address reg, 2/3 memory |
| dreg_i | input | 32 | Data register contents |
| addr_i | input | AW | Operand base address |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Address of current beat |
| mem_size_o | output | 3 | Bytes in current beat |
| mem_rdata_i | input | 32 | Big-endian read data, right-justified |
| mem_ack_i | input | 1 | Beat accepted, data valid |
| mem_abort_i | input | 1 | Beat failed, end load |
| done_o | output | 1 | Load finished (one cycle) |
| illegal_o | output | 1 | Unsupported format/source combination |
| abort_o | output | 1 | Load ended by memory abort |
| res_sign_o | output | 1 | Result sign |
| res_exp_o | output | 15 | Result biased exponent |
| res_man_o | output | 64 | Result mantissa, explicit integer bit |

## Verification
The assertions assume the following about the memory side:
- it returns `mem_ack_i` or `mem_abort_i` only while `mem_req_o` is high;
- it does not raise both in the same cycle;
- `start_i` is only meaningful between loads.

The bench's memory model derives its acknowledge and abort from the live request, so neither can appear outside a request. An abort is injected on a chosen beat, and it suppresses the acknowledge. The only start pulse sent during a load is the one deliberately issued to check that it is ignored.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
  localparam int EXP_W = 15;
  localparam int MAN_W = 64;
  localparam int EXT_BIAS = 16383;
  localparam int BUF_BYTES = 12;
  localparam int BUF_W = 8 * BUF_BYTES;
  localparam int BEAT_W = $clog2(BUF_BYTES);

  typedef enum logic [2:0] {
    FMT_LONG = 3'd0, FMT_SGL = 3'd1, FMT_EXT = 3'd2, FMT_PKS = 3'd3,
    FMT_WORD = 3'd4, FMT_DBL = 3'd5, FMT_BYTE = 3'd6, FMT_PKD = 3'd7
  } fmt_e;

  typedef enum logic [1:0] {
    SRC_DREG = 2'd0, SRC_AREG = 2'd1, SRC_MEM = 2'd2, SRC_MEM2 = 2'd3
  } src_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } ext_t;

  function automatic logic [3:0] fmt_bytes(input fmt_e f);
    case (f)
      FMT_BYTE:                   return 4'd1;
      FMT_WORD:                   return 4'd2;
      FMT_LONG, FMT_SGL:          return 4'd4;
      FMT_DBL:                    return 4'd8;
      default:                    return 4'd12;
    endcase
  endfunction

  function automatic logic fmt_reg_ok(input fmt_e f);
    return (f == FMT_BYTE) || (f == FMT_WORD) || (f == FMT_LONG) || (f == FMT_SGL);
  endfunction
endpackage

// File: rtl/fpl_lzc.sv
module fpl_lzc #(
  parameter int W = 64
) (
  input  logic [W-1:0]           a_i,
  output logic [$clog2(W+1)-1:0] cnt_o
);
  localparam int CW = $clog2(W+1);

  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++)
      if (a_i[i]) cnt_o = CW'(W - 1 - i);
  end
endmodule

// File: rtl/fpl_int_cvt.sv
module fpl_int_cvt
  import fpl_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic [IW-1:0] val_i,
  output ext_t          res_o
);
  localparam int CW = $clog2(IW+1);

  logic [IW-1:0] mag;
  logic [CW-1:0] lz;

  assign mag = val_i[IW-1] ? (~val_i + IW'(1)) : val_i;

  fpl_lzc #(.W(IW)) u_lzc (.a_i(mag), .cnt_o(lz));

  always_comb begin
    res_o = '0;
    if (mag != '0) begin
      res_o.sign = val_i[IW-1];
      res_o.exp  = EXP_W'(EXT_BIAS + IW - 1) - EXP_W'(lz);
      res_o.man  = {mag << lz, {(MAN_W-IW){1'b0}}};
    end
  end
endmodule

// File: rtl/fpl_ieee_cvt.sv
module fpl_ieee_cvt
  import fpl_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] bits_i,
  output ext_t           res_o
);
  localparam int BIAS = (1 << (EW-1)) - 1;
  localparam int REBIAS = EXT_BIAS - BIAS;
  localparam int CW = $clog2(MAN_W+1);

  logic [EW-1:0]    e;
  logic [FW-1:0]    f;
  logic [MAN_W-1:0] fpad;
  logic [CW-1:0]    lz;

  assign e    = bits_i[EW+FW-1:FW];
  assign f    = bits_i[FW-1:0];
  assign fpad = {f, {(MAN_W-FW){1'b0}}};

  fpl_lzc #(.W(MAN_W)) u_lzc (.a_i(fpad), .cnt_o(lz));

  always_comb begin
    res_o      = '0;
    res_o.sign = bits_i[EW+FW];
    if (e == '1) begin
      res_o.exp = '1;
      res_o.man = {1'b0, f, {(MAN_W-FW-1){1'b0}}};
    end else if (e != '0) begin
      res_o.exp = EXP_W'(e) + EXP_W'(REBIAS);
      res_o.man = {1'b1, f, {(MAN_W-FW-1){1'b0}}};
    end else if (f != '0) begin
      // denormal: value 0.f * 2^(1-bias), renormalised
      res_o.exp = EXP_W'(REBIAS) - EXP_W'(lz);
      res_o.man = fpad << lz;
    end
  end
endmodule

// File: rtl/fpl_fetch.sv
module fpl_fetch
  import fpl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        fmt_i,
  input  logic [1:0]        src_i,
  input  logic [31:0]       dreg_i,
  input  logic [AW-1:0]     addr_i,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [2:0]        mem_size_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              mem_abort_i,
  output logic              done_o,
  output logic              illegal_o,
  output logic              abort_o,
  output fmt_e              fmt_o,
  output logic [31:0]       word_o,
  output logic [BUF_W-1:0]  buf_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} state_e;

  state_e            state_q;
  fmt_e              fmt_q;
  logic [AW-1:0]     base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [31:0]       word_q;
  logic [7:0]        buf_q [BUF_BYTES];
  logic              ill_q, abort_q;

  fmt_e        fmt_new;
  src_e        src_new;
  logic        ill_new;
  logic [3:0]  nbytes;
  logic        multi;

  assign fmt_new = fmt_e'(fmt_i);
  assign src_new = src_e'(src_i);
  assign nbytes  = fmt_bytes(fmt_q);
  assign multi   = nbytes > 4'd4;

  always_comb begin
    unique case (src_new)
      SRC_DREG: ill_new = !fmt_reg_ok(fmt_new);
      SRC_AREG: ill_new = 1'b1;
      default:  ill_new = (fmt_new == FMT_PKS) || (fmt_new == FMT_PKD);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fmt_q   <= FMT_LONG;
      base_q  <= '0;
      beat_q  <= '0;
      word_q  <= '0;
      ill_q   <= 1'b0;
      abort_q <= 1'b0;
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          fmt_q   <= fmt_new;
          base_q  <= addr_i;
          beat_q  <= '0;
          ill_q   <= 1'b0;
          abort_q <= 1'b0;
          if (ill_new) begin
            ill_q   <= 1'b1;
            state_q <= ST_DONE;
          end else if (src_new == SRC_DREG) begin
            word_q  <= dreg_i;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_abort_i) begin
            abort_q <= 1'b1;
            state_q <= ST_DONE;
          end else if (mem_ack_i) begin
            if (multi) buf_q[beat_q] <= mem_rdata_i[7:0];
            else       word_q        <= mem_rdata_i;
            if (!multi || beat_q == BEAT_W'(nbytes - 4'd1)) state_q <= ST_DONE;
            else beat_q <= beat_q + BEAT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_FETCH);
  assign mem_addr_o = base_q + AW'(beat_q);
  assign mem_size_o = multi ? 3'd1 : nbytes[2:0];
  assign done_o     = (state_q == ST_DONE);
  assign illegal_o  = done_o && ill_q;
  assign abort_o    = done_o && abort_q;
  assign fmt_o      = fmt_q;
  assign word_o     = word_q;

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_buf
    assign buf_o[BUF_W-1-8*g -: 8] = buf_q[g];
  end

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !mem_abort_i |=>
      mem_req_o && $stable(mem_addr_o) && $stable(mem_size_o));
  a_r1_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && !mem_abort_i |=>
      !mem_req_o || (mem_addr_o == $past(mem_addr_o) + AW'(1)));
  a_r3_areg_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && !done_o && start_i && src_i == 2'd1 |=> !mem_req_o && done_o);
  a_r9_abort_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_abort_i |=> !mem_req_o && abort_o);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/fp_src_loader.sv
module fp_src_loader
  import fpl_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       fmt_i,
  input  logic [1:0]       src_i,
  input  logic [31:0]      dreg_i,
  input  logic [AW-1:0]    addr_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [2:0]       mem_size_o,
  input  logic [31:0]      mem_rdata_i,
  input  logic             mem_ack_i,
  input  logic             mem_abort_i,
  output logic             done_o,
  output logic             illegal_o,
  output logic             abort_o,
  output logic             res_sign_o,
  output logic [EXP_W-1:0] res_exp_o,
  output logic [MAN_W-1:0] res_man_o
);
  fmt_e             fmt;
  logic [31:0]      word;
  logic [BUF_W-1:0] buff;
  logic [31:0]      int_val;
  ext_t             r_int, r_sgl, r_dbl, r_ext, r_sel;
  logic             unused_pad;

  fpl_fetch #(.AW(AW)) u_fetch (
    .clk_i, .rst_ni, .start_i, .fmt_i, .src_i, .dreg_i, .addr_i,
    .mem_req_o, .mem_addr_o, .mem_size_o, .mem_rdata_i, .mem_ack_i, .mem_abort_i,
    .done_o, .illegal_o, .abort_o,
    .fmt_o(fmt), .word_o(word), .buf_o(buff)
  );

  always_comb begin
    unique case (fmt)
      FMT_BYTE: int_val = {{24{word[7]}}, word[7:0]};
      FMT_WORD: int_val = {{16{word[15]}}, word[15:0]};
      default:  int_val = word;
    endcase
  end

  fpl_int_cvt #(.IW(32)) u_int (.val_i(int_val), .res_o(r_int));
  fpl_ieee_cvt #(.EW(8),  .FW(23)) u_sgl (.bits_i(word), .res_o(r_sgl));
  fpl_ieee_cvt #(.EW(11), .FW(52)) u_dbl (.bits_i(buff[BUF_W-1 -: 64]), .res_o(r_dbl));

  // bytes 0-1 sign/exponent, 2-3 pad, 4-11 mantissa
  assign r_ext      = {buff[BUF_W-1 -: 16], buff[MAN_W-1:0]};
  assign unused_pad = ^buff[BUF_W-17 -: 16];

  always_comb begin
    unique case (fmt)
      FMT_BYTE, FMT_WORD, FMT_LONG: r_sel = r_int;
      FMT_SGL:                      r_sel = r_sgl;
      FMT_DBL:                      r_sel = r_dbl;
      FMT_EXT:                      r_sel = r_ext;
      default:                      r_sel = '0;
    endcase
    if (!done_o || illegal_o || abort_o) r_sel = '0;
  end

  assign res_sign_o = r_sel.sign;
  assign res_exp_o  = r_sel.exp;
  assign res_man_o  = r_sel.man;

  a_r5_normalised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !illegal_o && !abort_o && fmt != FMT_EXT &&
    res_exp_o != '0 && res_exp_o != '1 |-> res_man_o[MAN_W-1]);
  a_r10_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o || abort_o |-> done_o && res_man_o == '0 && res_exp_o == '0 && !res_sign_o);
  a_r9_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({illegal_o, abort_o}));
  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> res_man_o == '0 && res_exp_o == '0);
endmodule

// File: tb/fp_src_loader_test.sv
module fp_src_loader_test;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  fmt_i = '0;
  logic [1:0]  src_i = '0;
  logic [31:0] dreg_i = '0;
  logic [31:0] addr_i = BASE;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic [2:0]  mem_size_o;
  logic [31:0] mem_rdata_i;
  logic        mem_ack_i, mem_abort_i;
  logic        done_o, illegal_o, abort_o, res_sign_o;
  logic [14:0] res_exp_o;
  logic [63:0] res_man_o;

  int   n_chk = 0, n_fail = 0, req_cycles = 0;
  logic [7:0] mem_b [16];
  logic       stall_en = 1'b0, tog = 1'b0, abort_en = 1'b0;
  int         abort_beat = 0;
  logic [3:0] idx;

  always #4 clk = ~clk;

  fp_src_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .fmt_i, .src_i, .dreg_i, .addr_i,
    .mem_req_o, .mem_addr_o, .mem_size_o, .mem_rdata_i, .mem_ack_i, .mem_abort_i,
    .done_o, .illegal_o, .abort_o, .res_sign_o, .res_exp_o, .res_man_o
  );

  always @(posedge clk) begin
    tog <= ~tog;
    if (mem_req_o) req_cycles <= req_cycles + 1;
  end

  always_comb begin
    idx = 4'(mem_addr_o - BASE);
    case (mem_size_o)
      3'd1:    mem_rdata_i = {24'h0, mem_b[idx]};
      3'd2:    mem_rdata_i = {16'h0, mem_b[idx], mem_b[idx+4'd1]};
      default: mem_rdata_i = {mem_b[idx], mem_b[idx+4'd1], mem_b[idx+4'd2], mem_b[idx+4'd3]};
    endcase
    mem_abort_i = mem_req_o && abort_en && (int'(idx) == abort_beat);
    mem_ack_i   = mem_req_o && !mem_abort_i && (!stall_en || tog);
  end

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] ref_int(input logic [31:0] v);
    logic [31:0] m;
    int p;
    m = v[31] ? (~v + 32'd1) : v;
    if (m == 0) return '0;
    p = 0;
    for (int i = 0; i < 32; i++) if (m[i]) p = i;
    return {v[31], 15'(16383 + p), {m, 32'h0} << (31 - p)};
  endfunction

  function automatic logic [79:0] ref_fp(input logic [63:0] bits, input int ew, input int fw);
    logic [63:0] f;
    int e, bias, p;
    logic s;
    s    = bits[ew+fw];
    e    = int'((bits >> fw) & ((64'd1 << ew) - 64'd1));
    f    = bits & ((64'd1 << fw) - 64'd1);
    bias = (1 << (ew-1)) - 1;
    if (e == 0 && f == 0) return {s, 79'h0};
    if (e == (1 << ew) - 1) return {s, 15'h7FFF, f << (63 - fw)};
    if (e == 0) begin
      p = 0;
      for (int i = 0; i < 64; i++) if (f[i]) p = i;
      return {s, 15'(16383 + p + 1 - bias - fw), f << (63 - p)};
    end
    return {s, 15'(e - bias + 16383), 64'h8000_0000_0000_0000 | (f << (63 - fw))};
  endfunction

  task automatic put_word(input logic [31:0] v, input int n);
    for (int k = 0; k < 16; k++) mem_b[k] = 8'(8'hC3 ^ k);
    for (int k = 0; k < n; k++) mem_b[k] = v[8*(n-1-k) +: 8];
  endtask

  task automatic put_wide(input logic [95:0] v, input int n);
    for (int k = 0; k < 16; k++) mem_b[k] = 8'(8'h3C ^ k);
    for (int k = 0; k < n; k++) mem_b[k] = v[95-8*k -: 8];
  endtask

  task automatic do_load(input logic [2:0] fmt, input logic [1:0] src,
                         input logic [31:0] dreg, output int lat);
    @(negedge clk);
    fmt_i = fmt; src_i = src; dreg_i = dreg; addr_i = BASE; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic logic [79:0] res();
    return {res_sign_o, res_exp_o, res_man_o};
  endfunction

  initial begin
    int lat, rc;
    logic [79:0] er;
    logic [31:0] sg [10] = '{32'h0, 32'h8000_0000, 32'h3F80_0000, 32'h0000_0001,
                             32'h807F_FFFF, 32'h0080_0000, 32'h7F80_0000, 32'hFF80_0001,
                             32'h7F7F_FFFF, 32'hC049_0FDB};
    logic [63:0] db [11] = '{64'h0, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
                             64'hC000_0000_0000_0000, 64'h0000_0000_0000_0001,
                             64'h800F_FFFF_FFFF_FFFF, 64'h7FF0_0000_0000_0000,
                             64'h7FF8_0000_0000_0001, 64'h7FEF_FFFF_FFFF_FFFF,
                             64'h0010_0000_0000_0000, 64'h4009_21FB_5444_2D18};
    logic [95:0] ex [4] = '{96'h3FFF_ABCD_8000_0000_0000_0000, 96'hC00E_1234_C90F_DAA2_2168_C235,
                            96'h7FFF_FFFF_0000_0000_0000_0001, 96'h8000_5A5A_0000_0000_0000_0000};
    logic [31:0] lg [6] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678};

    for (int k = 0; k < 16; k++) mem_b[k] = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset done", {79'h0, done_o}, 80'h0);
    chk("R11 reset req", {79'h0, mem_req_o}, 80'h0);
    rst_n = 1'b1;

    // R2/R5: register byte sweep with upper garbage
    for (int i = 0; i < 256; i++) begin
      do_load(3'd6, 2'd0, {24'hA5A5A5, 8'(i)}, lat);
      chk("R5 reg byte", res(), ref_int({{24{i[7]}}, 8'(i)}));
      chk("R2 reg latency", 80'(lat), 80'd1);
    end
    // R5: register word sweep
    for (int i = 0; i < 256; i++) begin
      logic [15:0] w;
      w = 16'(i * 257 + (i & 3));
      do_load(3'd4, 2'd0, {16'h5A5A, w}, lat);
      chk("R5 reg word", res(), ref_int({{16{w[15]}}, w}));
    end
    // R5: long walking ones, positive and negative
    for (int i = 0; i < 32; i++) begin
      do_load(3'd0, 2'd0, 32'd1 << i, lat);
      chk("R5 reg long pos", res(), ref_int(32'd1 << i));
      do_load(3'd0, 2'd0, ~(32'd1 << i) + 32'd1, lat);
      chk("R5 reg long neg", res(), ref_int(~(32'd1 << i) + 32'd1));
    end
    foreach (lg[i]) begin
      do_load(3'd0, 2'd0, lg[i], lat);
      chk("R5 reg long", res(), ref_int(lg[i]));
    end
    // R6/R7: single exponent sweep and special values from register
    for (int e = 0; e < 256; e++) begin
      logic [31:0] b;
      b = {e[1], 8'(e), 23'((e * 32'h1357) ^ 32'h2A5)};
      do_load(3'd1, 2'd0, b, lat);
      chk("R6 R7 single sweep", res(), ref_fp({32'h0, b}, 8, 23));
    end
    foreach (sg[i]) begin
      do_load(3'd1, 2'd0, sg[i], lat);
      chk("R7 single special", res(), ref_fp({32'h0, sg[i]}, 8, 23));
    end
    // R2: illegal register formats
    for (int f = 0; f < 8; f++) begin
      if (f == 2 || f == 3 || f == 5 || f == 7) begin
        do_load(3'(f), 2'd0, 32'hFFFF_FFFF, lat);
        chk("R2 reg illegal", {res(), illegal_o}, {80'h0, 1'b1});
        chk("R2 reg illegal latency", 80'(lat), 80'd1);
      end
    end
    // R3: address register source
    for (int f = 0; f < 8; f++) begin
      rc = req_cycles;
      do_load(3'(f), 2'd1, 32'h1, lat);
      chk("R3 areg illegal", {79'h0, illegal_o}, 80'h1);
      chk("R3 areg latency/no req", {48'(lat), 32'(req_cycles - rc)}, {48'd1, 32'd0});
    end
    // R4: packed from memory
    for (int s = 2; s < 4; s++) begin
      rc = req_cycles;
      do_load(3'd3, 2'(s), 32'h0, lat);
      chk("R4 packed static", {48'(lat), 31'(req_cycles - rc), illegal_o}, {48'd1, 31'd0, 1'b1});
      do_load(3'd7, 2'(s), 32'h0, lat);
      chk("R4 packed dynamic", {48'(lat), 31'(req_cycles - rc), illegal_o}, {48'd1, 31'd0, 1'b1});
    end
    // R1/R5/R6: small memory operands
    for (int i = 0; i < 16; i++) begin
      logic [31:0] v;
      v = 32'h8765_4321 ^ (32'h1111_1111 * i);
      put_word(v, 1); do_load(3'd6, 2'd2, 32'h0, lat);
      chk("R1 mem byte", {res(), 8'(lat)}, {ref_int({{24{v[7]}}, v[7:0]}), 8'd2});
      put_word(v, 2); do_load(3'd4, 2'd2, 32'h0, lat);
      chk("R1 mem word", {res(), 8'(lat)}, {ref_int({{16{v[15]}}, v[15:0]}), 8'd2});
      put_word(v, 4); do_load(3'd0, 2'(2 + (i & 1)), 32'h0, lat);
      chk("R1 mem long", {res(), 8'(lat)}, {ref_int(v), 8'd2});
      put_word(v, 4); do_load(3'd1, 2'd2, 32'h0, lat);
      chk("R6 mem single", {res(), 8'(lat)}, {ref_fp({32'h0, v}, 8, 23), 8'd2});
    end
    // R1/R6/R7: double from memory
    foreach (db[i]) begin
      put_wide({db[i], 32'h0}, 8);
      do_load(3'd5, 2'd2, 32'h0, lat);
      chk("R7 mem double", res(), ref_fp(db[i], 11, 52));
      chk("R1 double latency", 80'(lat), 80'd9);
    end
    // R8: extended, pad bytes varied
    foreach (ex[i]) begin
      for (int pad = 0; pad < 2; pad++) begin
        logic [95:0] v;
        v = ex[i];
        v[79:64] = pad ? 16'hFFFF : 16'h0000;
        put_wide(v, 12);
        do_load(3'd2, 2'd2, 32'h0, lat);
        chk("R8 mem extended", res(), {ex[i][95:80], ex[i][63:0]});
        chk("R1 extended latency", 80'(lat), 80'd13);
      end
    end
    // R9: abort on beat 5 of a double
    put_wide({db[2], 32'h0}, 8);
    abort_en = 1'b1; abort_beat = 5;
    rc = req_cycles;
    do_load(3'd5, 2'd2, 32'h0, lat);
    chk("R9 abort flags", {res(), abort_o, illegal_o}, {80'h0, 1'b1, 1'b0});
    chk("R9 abort timing", {48'(lat), 32'(req_cycles - rc)}, {48'd7, 32'd6});
    abort_en = 1'b0;
    @(negedge clk);
    chk("R9 no request after abort", {79'h0, mem_req_o}, 80'h0);
    // R10/R11: stalled extended load with a stray start mid-load
    stall_en = 1'b1;
    put_wide(ex[1], 12);
    @(negedge clk);
    fmt_i = 3'd2; src_i = 2'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    fmt_i = 3'd0; src_i = 2'd0; dreg_i = 32'd5; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 stray start ignored", res(), {ex[1][95:80], ex[1][63:0]});
    chk("R11 stall lengthens load", {79'h0, lat > 10}, 80'h1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 done pulse", {res(), done_o}, 81'h0);
    end
    stall_en = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule